// File: doc/BRIEF.md
# Burst SRAM Control Front-End

This block is the clocked control path of a pipelined burst static RAM with a 20-bit word address and two byte lanes. On each rising clock edge it samples two address strobes, three chip enables, an advance input and the write controls. It then decides whether to load a new address, deselect the part, step the burst, or hold. The two least significant address bits form a burst counter that wraps and never carries into the upper bits. A global write request overrides the byte-lane selects. The registered address and the per-lane write strobes drive a small behavioural word array. The array's read port shows the word at the current address.

A system uses the block the way a processor or memory controller uses a burst SRAM. One strobe cycle starts an access, and further cycles with the advance input low walk through the four-word group. The processor strobe always opens a read. The controller strobe can open a write at once.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After reset, active_o is 0, we_o is 0, addr_o is 0 and every array word reads 0.
- R2: When adsp_ni and ce1_ni are both low at an edge and the device is selected (ce1_ni low, ce2_i high, ce3_ni low), then after that edge addr_o equals the sampled addr_i, active_o is 1 and we_o is 0 (read start), whatever the write inputs.
- R3: When adsc_ni is low at an edge, the processor strobe is not acting (adsp_ni high or ce1_ni high) and the device is selected, then after that edge addr_o equals the sampled addr_i, active_o is 1 and we_o takes the decoded write mask of that edge.
- R4: adsp_ni has no effect at an edge where ce1_ni is high. The cycle behaves exactly as it would with adsp_ni high.
- R5: An acting strobe with the device not selected deselects it: active_o goes to 0, we_o to 0, and addr_o holds.
- R6: When both strobes are low with ce1_ni low, the processor strobe wins and the cycle is a read start (we_o = 0).
- R7: On an edge with no acting strobe while active_o is 1, adv_ni low increments addr_o[1:0] by one with 3 wrapping to 0 and addr_o[19:2] unchanged. adv_ni high holds addr_o.
- R8: On an edge with no acting strobe while active_o is 0, we_o becomes 0 and addr_o holds, regardless of adv_ni and the write inputs.
- R9: Write mask decode (we_o bit 0 = lane bits 7:0, bit 1 = bits 15:8): gw_ni low gives 2'b11. Otherwise bwe_ni low gives the inverse of bw_ni. Otherwise it gives 2'b00. The mask is applied on controller-strobe loads and on active continuation edges.
- R10: On the edge after a we_o bit is 1, that lane of array word addr_o[5:0] takes the wdata_i lane sampled one edge earlier. rdata_o always shows the word at addr_o[5:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Word address |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | 2 | Byte lane selects, active low |
| wdata_i | input | 16 | Write data, sampled with the write controls |
| addr_o | output | 20 | Registered burst address |
| we_o | output | 2 | Registered per-lane write strobes |
| active_o | output | 1 | Device selected and bursting |
| rdata_o | output | 16 | Array word at the current address |

## Verification
The bench builds the block with its defaults: a 20-bit address, two 8-bit lanes and a 64-word array indexed by the low six address bits. The array is small, so random full-width addresses alias onto words written earlier. Reads therefore check data from the write mask decode and not only reset contents. Random addresses often land near a group boundary, which brings burst wrap from 3 to 0 within reach together with unchanged upper bits. The strobe and enable probabilities make both-strobe collisions, processor strobes masked by ce1_ni, and deselects while bursting all common.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    STB_NONE = 2'd0,
    STB_PROC = 2'd1,
    STB_CTRL = 2'd2
  } strobe_e;
endpackage

// File: rtl/burst_sram_strobe.sv
module burst_sram_strobe
  import burst_sram_pkg::*;
(
  input  logic    adsp_ni,
  input  logic    adsc_ni,
  input  logic    ce1_ni,
  input  logic    ce2_i,
  input  logic    ce3_ni,
  output strobe_e kind_o,
  output logic    sel_o
);
  // processor strobe only counts while ce1 is low; it beats the controller strobe
  always_comb begin
    if (!adsp_ni && !ce1_ni)  kind_o = STB_PROC;
    else if (!adsc_ni)        kind_o = STB_CTRL;
    else                      kind_o = STB_NONE;
  end

  assign sel_o = !ce1_ni && ce2_i && !ce3_ni;
endmodule

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_e           kind_i,
  input  logic              sel_i,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [UPPER_W-1:0] upper_q;
  logic [BURST_W-1:0] burst_q;
  logic               active_q;
  logic               load, desel, step;

  assign load  = (kind_i != STB_NONE) && sel_i;
  assign desel = (kind_i != STB_NONE) && !sel_i;
  assign step  = (kind_i == STB_NONE) && active_q && !adv_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q  <= '0;
      burst_q  <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      upper_q  <= addr_i[ADDR_W-1:BURST_W];
      burst_q  <= addr_i[BURST_W-1:0];
      active_q <= 1'b1;
    end else if (desel) begin
      active_q <= 1'b0;
    end else if (step) begin
      burst_q  <= burst_q + 1'b1;  // wraps inside the group
    end
  end

  assign addr_o   = {upper_q, burst_q};
  assign active_o = active_q;
endmodule

// File: rtl/burst_sram_wdec.sv
module burst_sram_wdec
  import burst_sram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  strobe_e                 kind_i,
  input  logic                    sel_i,
  input  logic                    active_i,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES-1:0]        we_o,
  output logic [LANES*LANE_W-1:0] wdata_o
);
  logic             wr_ok;
  logic [LANES-1:0] mask;

  // writes only on controller loads or active continuation cycles
  assign wr_ok = ((kind_i == STB_CTRL) && sel_i) || ((kind_i == STB_NONE) && active_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l] = !gw_ni || (!bwe_ni && !bw_ni[l]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        we_o[l]                     <= 1'b0;
        wdata_o[l*LANE_W +: LANE_W] <= '0;
      end else begin
        we_o[l]                     <= wr_ok && mask[l];
        wdata_o[l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int MEM_AW = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [MEM_AW-1:0]       addr_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i[l]) begin
        mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int MEM_AW  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [LANES-1:0]        we_o,
  output logic                    active_o,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DATA_W = LANES * LANE_W;

  strobe_e           kind;
  logic              sel;
  logic [DATA_W-1:0] wdata_q;

  burst_sram_strobe u_strobe (
    .adsp_ni (adsp_ni),
    .adsc_ni (adsc_ni),
    .ce1_ni  (ce1_ni),
    .ce2_i   (ce2_i),
    .ce3_ni  (ce3_ni),
    .kind_o  (kind),
    .sel_o   (sel)
  );

  burst_sram_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .sel_i    (sel),
    .adv_ni   (adv_ni),
    .addr_i   (addr_i),
    .addr_o   (addr_o),
    .active_o (active_o)
  );

  burst_sram_wdec #(.LANES(LANES), .LANE_W(LANE_W)) u_wdec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .sel_i    (sel),
    .active_i (active_o),
    .gw_ni    (gw_ni),
    .bwe_ni   (bwe_ni),
    .bw_ni    (bw_ni),
    .wdata_i  (wdata_i),
    .we_o     (we_o),
    .wdata_o  (wdata_q)
  );

  burst_sram_array #(.MEM_AW(MEM_AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_o[MEM_AW-1:0]),
    .we_i    (we_o),
    .wdata_i (wdata_q),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adsp_ni,
  input logic              adsc_ni,
  input logic              adv_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              gw_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [LANES-1:0]  we_o,
  input logic              active_o
);
  logic p_act, c_act, dev_on;
  assign p_act  = !adsp_ni && !ce1_ni;
  assign c_act  = !adsc_ni && !p_act;
  assign dev_on = !ce1_ni && ce2_i && !ce3_ni;

  // R2
  proc_read_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_act && dev_on) |=> (active_o && we_o == '0 && addr_o == $past(addr_i)));

  // R5
  deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((p_act || c_act) && !dev_on) |=> (!active_o && we_o == '0 && $stable(addr_o)));

  // R7
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p_act && adsc_ni && active_o && !adv_ni) |=>
      (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1 && addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p_act && adsc_ni && !active_o) |=> (we_o == '0 && $stable(addr_o)));

  // R9
  global_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_act && dev_on && !gw_ni) |=> (we_o == {LANES{1'b1}}));
endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .adsp_ni  (adsp_ni),
  .adsc_ni  (adsc_ni),
  .adv_ni   (adv_ni),
  .ce1_ni   (ce1_ni),
  .ce2_i    (ce2_i),
  .ce3_ni   (ce3_ni),
  .gw_ni    (gw_ni),
  .addr_o   (addr_o),
  .we_o     (we_o),
  .active_o (active_o)
);

// File: tb/burst_sram_ctrl_tb.sv
module burst_sram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]  bw_n = 2'b11;
  logic [15:0] wdata = '0;
  logic [19:0] addr_o;
  logic [1:0]  we_o;
  logic        active_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  burst_sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_ni(adsp_n), .adsc_ni(adsc_n),
    .adv_ni(adv_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .bw_ni(bw_n), .wdata_i(wdata), .addr_o(addr_o), .we_o(we_o),
    .active_o(active_o), .rdata_o(rdata_o)
  );

  // behavioural reference
  logic [15:0] m_mem [64];
  logic [19:0] m_addr;
  logic [1:0]  m_we;
  logic [15:0] m_wd;
  logic        m_act;
  string       tag_st, tag_we;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 16'h0;
      m_addr = '0; m_we = '0; m_wd = '0; m_act = 1'b0;
      tag_st = "R1"; tag_we = "R1";
    end else begin
      bit p, c, s;
      logic [1:0] msk;
      if (m_we[0]) m_mem[m_addr % 64][7:0]  = m_wd[7:0];
      if (m_we[1]) m_mem[m_addr % 64][15:8] = m_wd[15:8];
      p = (adsp_n == 1'b0) && (ce1_n == 1'b0);
      c = (adsc_n == 1'b0) && !p;
      s = (ce1_n == 1'b0) && (ce2 == 1'b1) && (ce3_n == 1'b0);
      if (!gw_n)       msk = 2'b11;
      else if (!bwe_n) msk = ~bw_n;
      else             msk = 2'b00;
      if (p || c) begin
        if (s) begin
          m_addr = addr; m_act = 1'b1;
          if (p) begin
            m_we = 2'b00;
            tag_st = (adsc_n == 1'b0) ? "R6" : "R2"; tag_we = tag_st;
          end else begin
            m_we = msk; tag_st = "R3"; tag_we = "R9";
          end
        end else begin
          m_act = 1'b0; m_we = 2'b00; tag_st = "R5"; tag_we = "R5";
        end
      end else if (m_act) begin
        if (!adv_n) m_addr = {m_addr[19:2], 2'((m_addr[1:0] + 1) % 4)};
        m_we = msk;
        tag_st = (adsp_n == 1'b0) ? "R4" : "R7"; tag_we = "R9";
      end else begin
        m_we = 2'b00;
        tag_st = (adsp_n == 1'b0) ? "R4" : "R8"; tag_we = "R8";
      end
      m_wd = wdata;
    end
  end

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp(tag_st, "active_o", 32'(active_o), 32'(m_act));
    cmp(tag_st, "addr_o",   32'(addr_o),   32'(m_addr));
    cmp(tag_we, "we_o",     32'(we_o),     32'(m_we));
    cmp("R10",  "rdata_o",  32'(rdata_o),  32'(m_mem[m_addr % 64]));  // R10
  endtask

  task automatic drive_random(input bit burst_bias);
    adsp_n = ($urandom_range(99) < (burst_bias ? 10 : 30)) ? 1'b0 : 1'b1;
    adsc_n = ($urandom_range(99) < (burst_bias ? 10 : 30)) ? 1'b0 : 1'b1;
    ce1_n  = ($urandom_range(99) < 80) ? 1'b0 : 1'b1;
    ce2    = ($urandom_range(99) < 85) ? 1'b1 : 1'b0;
    ce3_n  = ($urandom_range(99) < 85) ? 1'b0 : 1'b1;
    adv_n  = ($urandom_range(99) < 60) ? 1'b0 : 1'b1;
    gw_n   = ($urandom_range(99) < 20) ? 1'b0 : 1'b1;
    bwe_n  = 1'($urandom_range(1));
    bw_n   = 2'($urandom_range(3));
    addr   = 20'($urandom);
    wdata  = 16'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    rst_n = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k > 0) compare_all();
      drive_random(k >= 2000);
    end
    @(negedge clk);
    compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule